// File: doc/BRIEF.md
# Banked Window Address Translator

This block sits between a cartridge-side bus and two memories: a 64 KiB flash and a 32 KiB RAM. It holds the state of three movable windows and turns each access in the 4 KiB cartridge space (offsets $1000 to $1FFF of a 13-bit address) into a physical memory address. It also produces a memory-type select, a read enable and a write enable. A separate hotspot decoder, which is not part of this block, issues update commands. The commands reload a window, flip one of its block bits, or load the pixel-helper bits of the low window.

The low window is 2 KiB and covers $1000 to $17FF. The mid window covers $1800 to $1DFF and shows only the first 1.5 KiB of a 2 KiB block. The page window is 256 bytes at $1E00. The last page, $1F00 to $1FFF, is fixed to the top page of flash. Flash blocks for the low window always come from the bottom half of flash, and flash blocks for the mid window always come from the top half. The translation is combinational on the bus address. A command changes the mapping from the clock edge that accepts it.

Top module: `bw_translator`

## Requirements
- R1: After reset, the low window maps flash block 0, the mid window maps flash block 16 (so $1800 reads flash $8000), and the page window maps flash page 0.
- R2: The low window's physical page is (window base page + bus_addr[10:8]) mod 128. In flash, mem_addr[15] is always 0, whatever bit 4 of the block argument holds. In RAM, the address is 15 bits with mem_addr[15]=0.
- R3: The mid window uses the same page sum. In flash, mem_addr[15] is always 1.
- R4: The page window maps flash page cmd_arg[7:0] (mem_addr = {page, bus_addr[7:0]}) or RAM page cmd_arg[6:0].
- R5: Any access to $1F00 to $1FFF maps flash address {8'hFF, bus_addr[7:0]} and never RAM.
- R6: Op codes on cmd_op, applied at the clock edge where cmd_valid=1:
  - 1 and 2 load a flash or RAM block cmd_arg[3:0] into the low window.
  - 3 and 4 do the same for the mid window.
  - 5 and 6 load a flash or RAM page into the page window.
  - 0 and 12 to 15 change nothing.
  - A block load sets the base page to block*8.
- R7: Op codes 7 and 8 invert bit A11 and bit A12 of the low window base (base page bits 3 and 4). Op codes 9 and 10 do the same for the mid window.
- R8: Op code 11 sets low base page bit 3 to cmd_arg[3] and bits 2:0 to cmd_arg[6:4]. The low window's memory type is kept.
- R9: A read in the cartridge space asserts mem_oe. A write asserts mem_we only when the target window is RAM. A write to flash asserts neither enable.
- R10: With bus_en=0, or with bus_addr[12]=0, mem_oe, mem_we, mem_sel_ram and mem_addr are all 0.
- R11: While cmd_valid=0, the window state does not change, whatever cmd_op and cmd_arg hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Update command strobe |
| cmd_op | input | 4 | Update op code |
| cmd_arg | input | 8 | Op argument (block, page or helper byte) |
| bus_en | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Cartridge bus address |
| mem_addr | output | 16 | Physical flash or RAM address |
| mem_sel_ram | output | 1 | 1 = RAM, 0 = flash |
| mem_oe | output | 1 | Memory read enable |
| mem_we | output | 1 | RAM write enable |

## Verification
Translation has no register on its path, so the four memory outputs are due in the same cycle as the bus inputs. The bench changes the bus on the falling edge and samples 1 ns later. A command takes effect at the first rising edge with cmd_valid high. The bench therefore holds the command for exactly one rising edge, drops it on the next falling edge, and only then probes the bus. Every expected address comes from a bench-side window model that is updated at the same point.

// File: rtl/bw_pkg.sv
package bw_pkg;
    localparam int unsigned BW_BLK_PG_W = 7;
    localparam int unsigned BW_UP_PG_W  = 8;

    typedef enum logic [3:0] {
        OP_NOP      = 4'd0,
        OP_LO_FLASH = 4'd1,
        OP_LO_RAM   = 4'd2,
        OP_MID_FLASH= 4'd3,
        OP_MID_RAM  = 4'd4,
        OP_UP_FLASH = 4'd5,
        OP_UP_RAM   = 4'd6,
        OP_LO_T11   = 4'd7,
        OP_LO_T12   = 4'd8,
        OP_MID_T11  = 4'd9,
        OP_MID_T12  = 4'd10,
        OP_HIRES    = 4'd11
    } bw_op_e;

    typedef enum logic [2:0] {
        RG_NONE, RG_LOW, RG_MID, RG_UP, RG_TOP
    } bw_region_e;

    typedef struct packed {
        logic                   lo_ram;
        logic [BW_BLK_PG_W-1:0] lo_pg;
        logic                   mid_ram;
        logic [BW_BLK_PG_W-1:0] mid_pg;
        logic                   up_ram;
        logic [BW_UP_PG_W-1:0]  up_pg;
    } bw_state_t;
endpackage

// File: rtl/bw_bank_regs.sv
module bw_bank_regs
    import bw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [3:0] cmd_op,
    input  logic [7:0] cmd_arg,
    output bw_state_t  state_q
);
    bw_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (cmd_valid) begin
            case (cmd_op)
                OP_LO_FLASH:  begin state_d.lo_ram = 1'b0;  state_d.lo_pg = {cmd_arg[3:0], 3'b000}; end
                OP_LO_RAM:    begin state_d.lo_ram = 1'b1;  state_d.lo_pg = {cmd_arg[3:0], 3'b000}; end
                OP_MID_FLASH: begin state_d.mid_ram = 1'b0; state_d.mid_pg = {cmd_arg[3:0], 3'b000}; end
                OP_MID_RAM:   begin state_d.mid_ram = 1'b1; state_d.mid_pg = {cmd_arg[3:0], 3'b000}; end
                OP_UP_FLASH:  begin state_d.up_ram = 1'b0;  state_d.up_pg = cmd_arg; end
                OP_UP_RAM:    begin state_d.up_ram = 1'b1;  state_d.up_pg = {1'b0, cmd_arg[6:0]}; end
                OP_LO_T11:    state_d.lo_pg[3]  = ~state_q.lo_pg[3];
                OP_LO_T12:    state_d.lo_pg[4]  = ~state_q.lo_pg[4];
                OP_MID_T11:   state_d.mid_pg[3] = ~state_q.mid_pg[3];
                OP_MID_T12:   state_d.mid_pg[4] = ~state_q.mid_pg[4];
                OP_HIRES:     state_d.lo_pg[3:0] = {cmd_arg[3], cmd_arg[6:4]};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assert_toggle_lo_a11_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_LO_T11) |=> (state_q.lo_pg[3] != $past(state_q.lo_pg[3])));
    assert_toggle_mid_a12_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_MID_T12) |=> (state_q.mid_pg[4] != $past(state_q.mid_pg[4])));
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(state_q));
    assert_hires_keeps_type_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_HIRES) |=> $stable(state_q.lo_ram));
endmodule

// File: rtl/bw_region_decode.sv
module bw_region_decode
    import bw_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    output bw_region_e        region
);
    localparam int unsigned SEL_LO = ADDR_W - 5;

    always_comb begin
        if (!addr[ADDR_W-1])                          region = RG_NONE;
        else if (!addr[ADDR_W-2])                     region = RG_LOW;
        else if (addr[ADDR_W-2:SEL_LO] == 4'hF)       region = RG_TOP;
        else if (addr[ADDR_W-2:SEL_LO] == 4'hE)       region = RG_UP;
        else                                          region = RG_MID;
    end
endmodule

// File: rtl/bw_addr_map.sv
module bw_addr_map
    import bw_pkg::*;
#(
    parameter int unsigned FLASH_AW = 16,
    parameter int unsigned ADDR_W   = 13
) (
    input  bw_region_e          region,
    input  bw_state_t           state,
    input  logic [ADDR_W-1:0]   addr,
    output logic [FLASH_AW-1:0] phys,
    output logic                is_ram
);
    localparam int unsigned N_BLK_WIN = 2;
    localparam int unsigned WIN_PG_W  = 3;

    logic [BW_BLK_PG_W-1:0] base [N_BLK_WIN];
    logic [BW_BLK_PG_W-1:0] sum  [N_BLK_WIN];
    logic                   ram  [N_BLK_WIN];
    logic [FLASH_AW-1:0]    addr_w [N_BLK_WIN];

    assign base[0] = state.lo_pg;
    assign base[1] = state.mid_pg;
    assign ram[0]  = state.lo_ram;
    assign ram[1]  = state.mid_ram;

    for (genvar g = 0; g < N_BLK_WIN; g++) begin : g_blk
        localparam logic FLASH_MSB = (g == 1);
        assign sum[g] = base[g] + {{(BW_BLK_PG_W-WIN_PG_W){1'b0}}, addr[10:8]};
        assign addr_w[g] = ram[g] ? {1'b0, sum[g], addr[7:0]}
                                  : {FLASH_MSB, sum[g], addr[7:0]};
    end

    always_comb begin
        phys   = '0;
        is_ram = 1'b0;
        case (region)
            RG_LOW: begin phys = addr_w[0]; is_ram = ram[0]; end
            RG_MID: begin phys = addr_w[1]; is_ram = ram[1]; end
            RG_UP:  begin phys = {state.up_pg, addr[7:0]}; is_ram = state.up_ram; end
            RG_TOP: begin phys = {8'hFF, addr[7:0]}; is_ram = 1'b0; end
            default: ;
        endcase
    end
endmodule

// File: rtl/bw_translator.sv
module bw_translator
    import bw_pkg::*;
#(
    parameter int unsigned ADDR_W   = 13,
    parameter int unsigned FLASH_AW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [3:0]          cmd_op,
    input  logic [7:0]          cmd_arg,
    input  logic                bus_en,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic [FLASH_AW-1:0] mem_addr,
    output logic                mem_sel_ram,
    output logic                mem_oe,
    output logic                mem_we
);
    bw_state_t           state_q;
    bw_region_e          region;
    logic [FLASH_AW-1:0] phys;
    logic                is_ram;
    logic                active;

    bw_bank_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_arg(cmd_arg), .state_q(state_q)
    );

    bw_region_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .region(region)
    );

    bw_addr_map #(.FLASH_AW(FLASH_AW), .ADDR_W(ADDR_W)) u_map (
        .region(region), .state(state_q), .addr(bus_addr),
        .phys(phys), .is_ram(is_ram)
    );

    assign active      = bus_en && (region != RG_NONE);
    assign mem_addr    = active ? phys : '0;
    assign mem_sel_ram = active && is_ram;
    assign mem_oe      = active && !bus_wr;
    assign mem_we      = active && bus_wr && is_ram;

    assert_no_enable_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_en || !bus_addr[ADDR_W-1]) |-> (!mem_oe && !mem_we && !mem_sel_ram));
    assert_top_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_addr[ADDR_W-1:8] == 5'h1F) |-> (mem_addr[15:8] == 8'hFF && !mem_sel_ram));
    assert_flash_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_sel_ram && !mem_oe));
    assert_lo_flash_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_oe && !mem_sel_ram && bus_addr[ADDR_W-1:ADDR_W-2] == 2'b10) |-> !mem_addr[15]);
    assert_mid_flash_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_oe && !mem_sel_ram && bus_addr[ADDR_W-1:ADDR_W-2] == 2'b11 &&
         bus_addr[ADDR_W-2:9] != 3'b111) |-> mem_addr[15]);
endmodule

// File: tb/bw_translator_bench.sv
module bw_translator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [7:0]  cmd_arg = '0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [15:0] mem_addr;
    logic        mem_sel_ram, mem_oe, mem_we;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench-side window model
    bit       m_lo_ram, m_mid_ram, m_up_ram;
    bit [6:0] m_lo_pg, m_mid_pg;
    bit [7:0] m_up_pg;

    always #4 clk = ~clk;

    bw_translator u_bw_translator (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .mem_addr(mem_addr), .mem_sel_ram(mem_sel_ram), .mem_oe(mem_oe), .mem_we(mem_we)
    );

    task automatic model_reset();
        m_lo_ram = 0; m_mid_ram = 0; m_up_ram = 0;
        m_lo_pg = 0; m_mid_pg = 0; m_up_pg = 0;
    endtask

    task automatic send(input bit v, input bit [3:0] op, input bit [7:0] arg);
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 0; cmd_op = 0; cmd_arg = 0;
        if (v) begin
            case (op)
                4'd1: begin m_lo_ram = 0; m_lo_pg = {arg[3:0], 3'b0}; end
                4'd2: begin m_lo_ram = 1; m_lo_pg = {arg[3:0], 3'b0}; end
                4'd3: begin m_mid_ram = 0; m_mid_pg = {arg[3:0], 3'b0}; end
                4'd4: begin m_mid_ram = 1; m_mid_pg = {arg[3:0], 3'b0}; end
                4'd5: begin m_up_ram = 0; m_up_pg = arg; end
                4'd6: begin m_up_ram = 1; m_up_pg = {1'b0, arg[6:0]}; end
                4'd7: m_lo_pg[3] = ~m_lo_pg[3];
                4'd8: m_lo_pg[4] = ~m_lo_pg[4];
                4'd9: m_mid_pg[3] = ~m_mid_pg[3];
                4'd10: m_mid_pg[4] = ~m_mid_pg[4];
                4'd11: m_lo_pg[3:0] = {arg[3], arg[6:4]};
                default: ;
            endcase
        end
    endtask

    // expected {addr, ram, oe, we}
    function automatic bit [18:0] expect_out(bit en, bit wr, bit [12:0] a);
        bit [15:0] pa; bit r; bit [6:0] s;
        if (!en || !a[12]) return '0;
        if (!a[11]) begin
            s = m_lo_pg + {4'b0, a[10:8]}; r = m_lo_ram; pa = {1'b0, s, a[7:0]};
        end else if (a[11:8] == 4'hF) begin
            r = 0; pa = {8'hFF, a[7:0]};
        end else if (a[11:8] == 4'hE) begin
            r = m_up_ram; pa = {m_up_pg, a[7:0]};
        end else begin
            s = m_mid_pg + {4'b0, a[10:8]}; r = m_mid_ram; pa = {~r, s, a[7:0]};
        end
        return {pa, r, !wr, wr & r};
    endfunction

    task automatic probe(input bit en, input bit wr, input bit [12:0] a, input string req);
        bit [18:0] exp_v, act;
        @(negedge clk);
        bus_en = en; bus_wr = wr; bus_addr = a;
        #1;
        exp_v = expect_out(en, wr, a);
        act = {mem_addr, mem_sel_ram, mem_oe, mem_we};
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s addr=%h wr=%0b: actual {addr,ram,oe,we}=%h expected=%h",
                     req, a, wr, act, exp_v);
        end
    endtask

    task automatic t_reset_R1();
        probe(1, 0, 13'h1000, "R1");
        probe(1, 0, 13'h1805, "R1");
        probe(1, 0, 13'h1E10, "R1");
        probe(1, 0, 13'h1F34, "R5");
    endtask

    task automatic t_lower_R2();
        send(1, 4'd1, 8'h1A);               // bit4 set: flash MSB stays 0
        probe(1, 0, 13'h1123, "R2");
        probe(1, 0, 13'h17FF, "R2");
        send(1, 4'd2, 8'h05);
        probe(1, 0, 13'h1723, "R2");
    endtask

    task automatic t_middle_R3();
        send(1, 4'd3, 8'h03);
        probe(1, 0, 13'h1D44, "R3");
        send(1, 4'd4, 8'h0F);
        probe(1, 0, 13'h1A00, "R3");
    endtask

    task automatic t_upper_R4();
        send(1, 4'd5, 8'hC3);
        probe(1, 0, 13'h1E7F, "R4");
        send(1, 4'd6, 8'hFF);
        probe(1, 0, 13'h1E7F, "R4");
        probe(1, 0, 13'h1FFF, "R5");
    endtask

    task automatic t_toggle_R7();
        send(1, 4'd1, 8'h00);
        send(1, 4'd7, 8'h00);
        probe(1, 0, 13'h1000, "R7");
        send(1, 4'd8, 8'h00);
        probe(1, 0, 13'h1000, "R7");
        send(1, 4'd3, 8'h02);
        send(1, 4'd9, 8'h00);
        probe(1, 0, 13'h1900, "R7");
        send(1, 4'd10, 8'h00);
        probe(1, 0, 13'h1900, "R7");
    endtask

    task automatic t_hires_R8();
        send(1, 4'd2, 8'h03);
        send(1, 4'd11, 8'h7F);              // page low bits 1111, carry on page 2
        probe(1, 0, 13'h1200, "R8");
        send(1, 4'd11, 8'h20);
        probe(1, 0, 13'h1000, "R8");
    endtask

    task automatic t_write_R9();
        probe(1, 1, 13'h1010, "R9");        // low window is RAM
        send(1, 4'd3, 8'h01);
        probe(1, 1, 13'h1810, "R9");        // flash: no enables
        probe(1, 1, 13'h1F10, "R9");
        probe(1, 0, 13'h1810, "R9");
    endtask

    task automatic t_outside_R10();
        probe(1, 0, 13'h0F80, "R10");
        probe(1, 1, 13'h0071, "R10");
        probe(0, 0, 13'h1000, "R10");
    endtask

    task automatic t_ignored_R6_R11();
        send(0, 4'd2, 8'h0C);               // R11 strobe low
        probe(1, 0, 13'h1300, "R11");
        send(1, 4'd15, 8'hFF);              // R6 unused op
        probe(1, 0, 13'h1300, "R6");
        send(1, 4'd0, 8'h55);               // R6 no-op
        probe(1, 0, 13'h1E00, "R6");
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_R1();
        t_lower_R2();
        t_middle_R3();
        t_upper_R4();
        t_toggle_R7();
        t_hires_R8();
        t_write_R9();
        t_outside_R10();
        t_ignored_R6_R11();
        done = 1;
    end

    initial begin : watchdog
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule